// File: doc/BRIEF.md
# Interleaved Shared-RAM Video Controller

This block drives a 640x400 raster with 4 bits per pixel from a single byte-wide RAM that a processor also uses. It runs from the pixel clock and divides it by two to produce the processor clock, `phi2`. While `phi2` is low, the video fetcher owns the RAM. While `phi2` is high, the processor's address, write data and read/write strobe pass straight through to the RAM. Each fetched byte holds two pixels. Both pixels go through a 16-entry palette to a 6-bit colour output. The block also generates separate horizontal and vertical sync.

Software scrolls the picture by writing a display base address. The fetch pointer takes that address at the start of vertical blanking and wraps at the top of the RAM address space, so a scrolled frame stays contiguous. An interrupt is raised at the start of vertical blanking and stays raised until software acknowledges it. This gives software a tear-free moment to flip buffers.

The pixel stream toward the display has no valid/ready handshake, because a monitor cannot apply back-pressure. Data moves in and out on a fixed schedule. The processor side is also a plain strobed bus with no stall: every access completes within the high phase of `phi2`. The total line length must be even, so that every line starts in the video phase.

Top module: `vidshare_ctrl`

## Requirements
- R1: `phi2` is low during reset and toggles on every `clk` edge afterwards. It is low exactly when the horizontal counter is even, and that phase is the video phase.
- R2: In the video phase the RAM is enabled and read (`ram_ce_n`=0, `ram_oe_n`=0, `ram_we_n`=1). In the processor phase `ram_ce_n` follows `cpu_ram_sel`, and `ram_we_n` is low only when `cpu_ram_sel`=1 and `cpu_rw`=0.
- R3: Lines are 800 clocks: 640 active, then 16 front porch, 96 sync, 48 back porch. Frames are 449 lines: 400 active, 12 front porch, 2 sync, 35 back porch. `hsync_n` is active low and `vsync` is active high. `rgb` and both syncs show the counter position of two clocks earlier.
- R4: Each fetched byte gives two pixels, the upper nibble first and then the lower nibble. Each nibble indexes the palette. `rgb` packs red in bits 5:4, green in bits 3:2 and blue in bits 1:0.
- R5: `rgb` is 0 outside the active area, and after reset.
- R6: The first fetch of a frame reads the base address. Each later fetch reads the next byte, one byte per pixel pair. Rows are contiguous, so row r starts at base + r*320.
- R7: The fetch address wraps modulo 2^ADDR_W (128 KiB at the default width).
- R8: A base write takes effect only when the counters reach line 400, column 0. A frame already in progress keeps its base.
- R9: `irq` rises one clock after the counters reach line 400, column 0. It then holds until a processor write to register index 3. Reading index 3 returns `irq` in bit 0.
- R10: Registers are selected by `cpu_reg_sel` with `cpu_addr[4:0]`. Indices 0, 1 and 2 hold base bits 7:0, 15:8 and 16 and read back. Indices 16 to 31 hold palette entries 0 to 15 in data bits 5:0 and read back. A write commits at the end of a high `phi2` cycle.
- R11: In the processor phase, a read with `cpu_ram_sel` returns `ram_rdata` on `cpu_rdata`. A write drives `cpu_addr` on `ram_addr` and `cpu_wdata` on `ram_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | output | 1 | Processor clock, half the pixel rate |
| cpu_addr | input | ADDR_W | Processor address (RAM address or register index) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, valid while phi2 is high |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_ram_sel | input | 1 | Processor accesses the shared RAM |
| cpu_reg_sel | input | 1 | Processor accesses controller registers |
| irq | output | 1 | Vertical-blank interrupt, level |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rgb | output | COL_W | Colour, 2 bits per channel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The RAM address and strobes are combinational from the phase, so the bench checks them in the same cycle as the counter position or processor access that selects them. Colour and sync appear two clocks after the position that produced them. The scoreboard therefore queues each expected item with a due cycle equal to the position cycle plus two, and pops it only in that cycle. The interrupt is checked in every cycle against a model that sets it one clock after line 400, column 0 and clears it in the cycle after an acknowledge commits. Register and RAM effects are read back through the processor port after the commit edge.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  // register index decode on the processor port
  localparam int REG_IDX_W   = 5;
  localparam int PAL_SEL_BIT = 4;
  localparam int STAT_IDX    = 3;

  // per-pixel control carried alongside fetched data
  typedef struct packed {
    logic active;
    logic hs_n;
    logic vs;
    logic odd;
  } vsc_tag_t;
endpackage

// File: rtl/vsc_timing.sv
module vsc_timing #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 400,
  parameter int V_FP     = 12,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 35
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               phase,
  output vsc_pkg::vsc_tag_t  tag,
  output logic               fetch,
  output logic               vblank_start
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    tag.active   = (hcnt < H_ACT) && (vcnt < V_ACT);
    tag.hs_n     = !((hcnt >= HS_BEG) && (hcnt < HS_END));
    tag.vs       = (vcnt >= VS_BEG) && (vcnt < VS_END);
    tag.odd      = hcnt[0];
    phase        = hcnt[0];
    fetch        = tag.active && !hcnt[0];
    vblank_start = (hcnt == '0) && (vcnt == V_ACT);
  end
endmodule

// File: rtl/vsc_fetch.sv
module vsc_fetch #(
  parameter int ADDR_W = 17,
  parameter int PIX_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch,
  input  logic                reload,
  input  logic [ADDR_W-1:0]   reload_addr,
  input  logic [2*PIX_W-1:0]  ram_rdata,
  input  vsc_pkg::vsc_tag_t   tag_in,
  output logic [ADDR_W-1:0]   vid_addr,
  output vsc_pkg::vsc_tag_t   tag_s1,
  output logic [PIX_W-1:0]    pix_idx
);
  localparam int BYTE_W = 2 * PIX_W;

  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_addr <= '0;
      byte_q   <= '0;
      tag_s1   <= '{active: 1'b0, hs_n: 1'b1, vs: 1'b0, odd: 1'b0};
    end else begin
      tag_s1 <= tag_in;
      if (reload)
        vid_addr <= reload_addr;
      else if (fetch)
        vid_addr <= vid_addr + 1'b1;
      if (fetch)
        byte_q <= ram_rdata;
    end
  end

  // upper nibble first, lower nibble on the odd column
  assign pix_idx = tag_s1.odd ? byte_q[PIX_W-1:0] : byte_q[BYTE_W-1:PIX_W];
endmodule

// File: rtl/vsc_palette.sv
module vsc_palette #(
  parameter int PIX_W = 4,
  parameter int COL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIX_W-1:0]  cpu_idx,
  input  logic [COL_W-1:0]  wr_data,
  input  logic [PIX_W-1:0]  pix_idx,
  output logic [COL_W-1:0]  cpu_color,
  output logic [COL_W-1:0]  pix_color
);
  localparam int ENTRIES = 1 << PIX_W;

  logic [ENTRIES*COL_W-1:0] pal_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [COL_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && cpu_idx == PIX_W'(g))
        q <= wr_data;
    end
    assign pal_flat[g*COL_W +: COL_W] = q;
  end

  assign pix_color = pal_flat[pix_idx*COL_W +: COL_W];
  assign cpu_color = pal_flat[cpu_idx*COL_W +: COL_W];
endmodule

// File: rtl/vsc_regs.sv
module vsc_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vblank_start,
  output logic [ADDR_W-1:0] base_pend,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pend <= '0;
      irq       <= 1'b0;
    end else begin
      for (int b = 0; b < ADDR_W; b++)
        if (wr_en && sel == 4'(b / DATA_W))
          base_pend[b] <= wdata[b % DATA_W];
      if (vblank_start)
        irq <= 1'b1;
      else if (wr_en && sel == 4'(vsc_pkg::STAT_IDX))
        irq <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < ADDR_W; b++)
      if (sel == 4'(b / DATA_W))
        rdata[b % DATA_W] = base_pend[b];
    if (sel == 4'(vsc_pkg::STAT_IDX))
      rdata[0] = irq;
  end
endmodule

// File: rtl/vidshare_ctrl.sv
module vidshare_ctrl #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 400,
  parameter int V_FP     = 12,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 35,
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              phi2,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cpu_rw,
  input  logic              cpu_ram_sel,
  input  logic              cpu_reg_sel,
  output logic              irq,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [COL_W-1:0]  rgb,
  output logic              hsync_n,
  output logic              vsync
);
  import vsc_pkg::*;

  localparam int PIX_W = DATA_W / 2;

  logic              phase, fetch, vblank_start;
  vsc_tag_t          tag0, tag1;
  logic [ADDR_W-1:0] vid_addr, base_pend;
  logic [PIX_W-1:0]  pix_idx;
  logic [COL_W-1:0]  pix_color, cpu_color;
  logic [DATA_W-1:0] ctl_rdata;
  logic              reg_wr, pal_wr, ctl_wr;

  vsc_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .phase(phase), .tag(tag0),
    .fetch(fetch), .vblank_start(vblank_start)
  );

  vsc_fetch #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .reload(vblank_start),
    .reload_addr(base_pend), .ram_rdata(ram_rdata), .tag_in(tag0),
    .vid_addr(vid_addr), .tag_s1(tag1), .pix_idx(pix_idx)
  );

  assign reg_wr = phase && cpu_reg_sel && !cpu_rw;
  assign pal_wr = reg_wr && cpu_addr[PAL_SEL_BIT];
  assign ctl_wr = reg_wr && !cpu_addr[PAL_SEL_BIT];

  vsc_palette #(.PIX_W(PIX_W), .COL_W(COL_W)) u_palette (
    .clk(clk), .rst_n(rst_n), .wr_en(pal_wr),
    .cpu_idx(cpu_addr[PIX_W-1:0]), .wr_data(cpu_wdata[COL_W-1:0]),
    .pix_idx(pix_idx), .cpu_color(cpu_color), .pix_color(pix_color)
  );

  vsc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .sel(cpu_addr[3:0]),
    .wdata(cpu_wdata), .vblank_start(vblank_start),
    .base_pend(base_pend), .irq(irq), .rdata(ctl_rdata)
  );

  // output stage: colour and syncs two clocks behind the counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb     <= '0;
      hsync_n <= 1'b1;
      vsync   <= 1'b0;
    end else begin
      rgb     <= tag1.active ? pix_color : '0;
      hsync_n <= tag1.hs_n;
      vsync   <= tag1.vs;
    end
  end

  assign phi2      = phase;
  assign ram_wdata = cpu_wdata;

  // RAM ownership alternates with the processor clock phase
  always_comb begin
    if (!phase) begin
      ram_addr = vid_addr;
      ram_ce_n = 1'b0;
      ram_oe_n = 1'b0;
      ram_we_n = 1'b1;
    end else begin
      ram_addr = cpu_addr;
      ram_ce_n = !cpu_ram_sel;
      ram_oe_n = !(cpu_ram_sel && cpu_rw);
      ram_we_n = !(cpu_ram_sel && !cpu_rw);
    end
  end

  always_comb begin
    if (phase && cpu_ram_sel && cpu_rw)
      cpu_rdata = ram_rdata;
    else if (phase && cpu_reg_sel && cpu_rw)
      cpu_rdata = cpu_addr[PAL_SEL_BIT] ? DATA_W'(cpu_color) : ctl_rdata;
    else
      cpu_rdata = '0;
  end
endmodule

// File: rtl/vidshare_ctrl_chk.sv
module vidshare_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phi2,
  input logic       cpu_rw,
  input logic       cpu_ram_sel,
  input logic       cpu_reg_sel,
  input logic [4:0] cpu_reg,
  input logic       ram_ce_n,
  input logic       ram_oe_n,
  input logic       ram_we_n,
  input logic       irq,
  input logic       hsync_n,
  input logic       vsync,
  input logic [5:0] rgb
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  phi2_alt_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    phi2 != $past(phi2));

  // R2
  vid_phase_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (!ram_ce_n && !ram_oe_n && ram_we_n));

  // R2
  we_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (phi2 && cpu_ram_sel && !cpu_rw));

  // R5
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || vsync) |-> (rgb == 6'd0));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(phi2 && cpu_reg_sel && !cpu_rw && cpu_reg == 5'(vsc_pkg::STAT_IDX))) |=> irq);
endmodule

bind vidshare_ctrl vidshare_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_rw(cpu_rw),
  .cpu_ram_sel(cpu_ram_sel), .cpu_reg_sel(cpu_reg_sel), .cpu_reg(cpu_addr[4:0]),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
  .irq(irq), .hsync_n(hsync_n), .vsync(vsync), .rgb(rgb)
);

// File: tb/vidshare_ctrl_bench.sv
module vidshare_ctrl_bench;
  localparam int HA = 16, HFP = 2, HS = 4, HBP = 2;
  localparam int VA = 4, VFP = 1, VS = 1, VBP = 2;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int FT = HT * VT;
  localparam int AW = 10;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phi2, irq, ram_ce_n, ram_oe_n, ram_we_n, hsync_n, vsync;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata, ram_wdata, ram_rdata;
  logic          cpu_rw = 1'b1, cpu_ram_sel = 1'b0, cpu_reg_sel = 1'b0;
  logic [AW-1:0] ram_addr;
  logic [5:0]    rgb;

  vidshare_ctrl #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .ADDR_W(AW), .DATA_W(8), .COL_W(6)
  ) u_vidshare_ctrl (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rw(cpu_rw),
    .cpu_ram_sel(cpu_ram_sel), .cpu_reg_sel(cpu_reg_sel), .irq(irq),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .rgb(rgb), .hsync_n(hsync_n), .vsync(vsync)
  );

  always #10 clk = ~clk;

  // bench-owned RAM
  logic [7:0] mem [MSZ];
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk)
    if (!ram_ce_n && !ram_we_n) mem[ram_addr] <= ram_wdata;

  int kcnt = 0;
  always @(posedge clk)
    if (!rst_n) kcnt <= 0;
    else        kcnt <= kcnt + 1;

  int nvec = 0, nfail = 0;
  int m_pend = 0, m_live = 0;
  bit m_irq = 1'b0;
  int pal_m [16];

  // scoreboard queues
  int q_due[$], q_rgb[$], q_hs[$], q_vs[$], q_req[$];

  function automatic string rname(int code);
    case (code)
      4: return "R4";
      5: return "R5";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, kcnt);
    end
  endtask

  // predictor and monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int idx, h, v, raw, code, ex;
      bit act;
      idx = kcnt % FT; h = idx % HT; v = idx / HT;
      act = (h < HA) && (v < VA);
      if (h == 0 && v == VA) m_live = m_pend;
      if (h == 1 && v == VA) m_irq = 1'b1;
      chk("R1", int'(phi2), h % 2);
      chk("R9", int'(irq), int'(m_irq));
      raw = m_live + v * (HA / 2) + h / 2;
      if (!phi2) begin
        chk("R2", {29'd0, ram_ce_n, ram_oe_n, ram_we_n}, 1);
        if (act) begin
          if (raw >= MSZ) chk("R7", int'(ram_addr), raw % MSZ);
          else            chk("R6", int'(ram_addr), raw);
        end
      end else begin
        chk("R2", int'(ram_ce_n), int'(!cpu_ram_sel));
        chk("R2", int'(ram_we_n), int'(!(cpu_ram_sel && !cpu_rw)));
      end
      if (kcnt >= FT) begin
        if (act) begin
          ex = mem[raw % MSZ];
          ex = (h % 2 == 1) ? (ex & 15) : (ex >> 4);
          ex = pal_m[ex];
          code = (raw >= MSZ) ? 7 : ((m_pend != m_live) ? 8 : 4);
        end else begin
          ex = 0;
          code = 5;
        end
        q_due.push_back(kcnt + 2);
        q_rgb.push_back(ex);
        q_hs.push_back((h >= HA + HFP && h < HA + HFP + HS) ? 0 : 1);
        q_vs.push_back((v >= VA + VFP && v < VA + VFP + VS) ? 1 : 0);
        q_req.push_back(code);
      end
      while (q_due.size() > 0 && q_due[0] == kcnt) begin
        chk(rname(q_req[0]), int'(rgb), q_rgb[0]);
        chk("R3", int'(hsync_n), q_hs[0]);
        chk("R3", int'(vsync), q_vs[0]);
        void'(q_due.pop_front()); void'(q_rgb.pop_front());
        void'(q_hs.pop_front());  void'(q_vs.pop_front());
        void'(q_req.pop_front());
      end
    end
  end

  // driver: one processor access in a high phase of phi2
  task automatic cpu_acc(input bit is_reg, input bit wr, input int addr,
                         input int data, output int rd);
    @(negedge clk);
    while (phi2 !== 1'b1) @(negedge clk);
    cpu_addr = AW'(addr); cpu_wdata = 8'(data); cpu_rw = !wr;
    cpu_reg_sel = is_reg; cpu_ram_sel = !is_reg;
    #2;
    rd = int'(cpu_rdata);
    if (!is_reg && wr) begin
      chk("R11", int'(ram_addr), addr);
      chk("R11", int'(ram_wdata), data);
      chk("R2", int'(ram_we_n), 0);
    end
    @(negedge clk);
    cpu_reg_sel = 1'b0; cpu_ram_sel = 1'b0; cpu_rw = 1'b1;
  endtask

  task automatic wait_k(input int n);
    while (kcnt < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    nfail++;
    $display("FAIL R1 watchdog: got no completion, expected end before cycle limit");
    finish_run();
  end

  initial begin
    int d;
    for (int i = 0; i < MSZ; i++) mem[i] = 8'(i * 29 + 7);
    for (int i = 0; i < 16; i++) pal_m[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // reset state
    chk("R1", int'(phi2), 0);
    chk("R3", int'(hsync_n), 1);
    chk("R3", int'(vsync), 0);
    chk("R5", int'(rgb), 0);
    chk("R9", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: load palette during frame 0
    for (int i = 0; i < 16; i++) begin
      cpu_acc(1'b1, 1'b1, 16 + i, (i * 11 + 5) & 63, d);
      pal_m[i] = (i * 11 + 5) & 63;
    end
    cpu_acc(1'b1, 1'b0, 16 + 5, 0, d);
    chk("R10", d, pal_m[5]);

    // frame 1: interrupt pending from frame 0, acknowledge it
    wait_k(FT + 10);
    cpu_acc(1'b1, 1'b0, 3, 0, d);
    chk("R9", d & 1, 1);
    cpu_acc(1'b1, 1'b1, 3, 0, d);
    m_irq = 1'b0;
    chk("R9", int'(irq), 0);

    // R8: pending base near the top of RAM, frame 2 wraps (R7)
    cpu_acc(1'b1, 1'b1, 0, 8'hFC, d);
    cpu_acc(1'b1, 1'b1, 1, 8'h03, d);
    m_pend = 1020;
    cpu_acc(1'b1, 1'b0, 0, 0, d);
    chk("R10", d, 8'hFC);
    cpu_acc(1'b1, 1'b0, 1, 0, d);
    chk("R10", d, 8'h03);

    // frame 2 vblank: R11 RAM write and read, new base
    wait_k(2 * FT + 100);
    cpu_acc(1'b0, 1'b1, 5, 8'hA5, d);
    chk("R11", int'(mem[5]), 8'hA5);
    cpu_acc(1'b0, 1'b0, 5, 0, d);
    chk("R11", d, 8'hA5);
    cpu_acc(1'b1, 1'b1, 0, 40, d);
    cpu_acc(1'b1, 1'b1, 1, 0, d);
    m_pend = 40;

    // frame 3 vblank: palette change seen in frame 4, acknowledge again
    wait_k(3 * FT + 100);
    cpu_acc(1'b1, 1'b1, 16 + 3, 6'h2A, d);
    pal_m[3] = 6'h2A;
    cpu_acc(1'b1, 1'b1, 3, 0, d);
    m_irq = 1'b0;

    wait_k(5 * FT + 20);
    finish_run();
  end
endmodule